// File: doc/BRIEF.md
# Per-channel DMA request qualifier with periodic release timer

This block decides, for every channel of a DMA engine, whether that channel may move data in the current cycle. Each channel combines up to three request sources: a peripheral request line that belongs to the on-chip I/O address the channel reads from or writes to, one of two external request pins, and a tick from a shared periodic down-counter. All sources assigned to a channel are ANDed. An external pin or the timer therefore throttles a peripheral-paced transfer rather than adding to it. A channel with no source assigned, which is a memory-to-memory move, requests every cycle.

Software programs one configuration word per channel and two timer words through a single write port. The timer FSM moves through `TMR_IDLE` (stopped), `TMR_LOAD` (period copied into the counter) and `TMR_RUN` (counting down). Its transitions are IDLE→LOAD when the run bit is set, LOAD→RUN while run stays set, LOAD→IDLE and RUN→IDLE when run is cleared, and RUN→RUN with a reload on every tick. Each channel has a two-state release FSM: `PEND_EMPTY` goes to `PEND_HELD` on a tick when the timer is assigned, and `PEND_HELD` goes back to `PEND_EMPTY` on a consume or when the timer is unassigned. A consume is one transfer acknowledge in byte mode, or a buffer-done pulse in whole-buffer mode.

Top module: `dma_req_gate`

## Requirements
- R1: A channel's `req_vld` is the AND of every source assigned to it. With no source assigned it is 1.
- R2: The peripheral source is `periph_src_req` when config bit 0 (source is I/O) is set. Otherwise it is `periph_dst_req` when bit 1 (destination is I/O) is set. Otherwise it is 1. With both bits set, the source line governs.
- R3: Config bit 2 assigns an external pin and bit 3 picks pin 0 or pin 1. The pin passes through a two-flop synchronizer, so a level change reaches `req_vld` after the second rising edge.
- R4: Address N_CH holds the period P. Address N_CH+1 holds bit 0 (run) and bit 1 (1 = whole buffer, 0 = single byte). While running, ticks come every P+1 cycles, so P = 0 gives a tick on every cycle.
- R5: Config bit 4 assigns the timer. A tick sets the channel's pending release, and a timer-gated channel requests only while a release is pending. Clearing bit 4 drops the pending release.
- R6: In byte mode one `xfer_ack` clears the pending release at the next edge, and `buf_done` has no effect.
- R7: In whole-buffer mode the release stays pending until `buf_done`, and `xfer_ack` has no effect.
- R8: A tick that arrives while a release is already pending is not counted twice: one consume empties it. A consume in the same cycle as a tick leaves the release pending.
- R9: `req_whole_buf` is 1 exactly when the channel has the timer assigned and whole-buffer mode is selected.
- R10: After reset every config and timer word is 0, no release is pending and every `req_vld` is 1.
- R11: Clearing the run bit stops ticks. A release that is already pending is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(N_CH+2) | Register address: channel 0..N_CH-1, period N_CH, control N_CH+1 |
| cfg_wdata | input | TMR_W | Write data |
| ext_req_in | input | 2 | Asynchronous external request pins |
| periph_src_req | input | N_CH | Peripheral request for each channel's source address |
| periph_dst_req | input | N_CH | Peripheral request for each channel's destination address |
| xfer_ack | input | N_CH | One byte moved on the channel |
| buf_done | input | N_CH | Channel finished its buffer |
| req_vld | output | N_CH | Qualified request per channel |
| req_whole_buf | output | N_CH | 1 = the release covers the whole buffer, 0 = one byte |

## Verification
The bench builds the block with N_CH = 4 and TMR_W = 16. Four channels are enough to cover both external pins, both peripheral-selection paths and timer-gated and ungated channels side by side. Timer periods of 0 and 40 bring the back-to-back tick case and exact tick spacing within a few hundred cycles. Randomly drawn channel configurations and input levels cover the AND combination. Directed sequences cover synchronizer latency, double ticks, mode-specific consumes and stopping the timer.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE,
        TMR_LOAD,
        TMR_RUN
    } tmr_state_t;

    typedef enum logic {
        PEND_EMPTY,
        PEND_HELD
    } pend_state_t;

    // bit 0 src_io, 1 dst_io, 2 ext_en, 3 ext_sel, 4 tmr_en
    typedef struct packed {
        logic tmr_en;
        logic ext_sel;
        logic ext_en;
        logic dst_io;
        logic src_io;
    } ch_cfg_t;

    localparam int CFG_BITS = 5;
    localparam int EXT_LINES = 2;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dma_req_timer.sv
module dma_req_timer
    import dma_req_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic             tick,
    output logic             buf_mode,
    output logic [CNT_W-1:0] period
);

    tmr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] period_q;
    logic             run_q;
    logic             buf_mode_q;

    // programmable words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            run_q      <= 1'b0;
            buf_mode_q <= 1'b0;
        end else begin
            if (period_we) begin
                period_q <= wdata;
            end
            if (ctl_we) begin
                run_q      <= wdata[0];
                buf_mode_q <= wdata[1];
            end
        end
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tick    = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (run_q) begin
                    state_d = TMR_LOAD;
                end
            end
            TMR_LOAD: begin
                cnt_d   = period_q;
                state_d = run_q ? TMR_RUN : TMR_IDLE;
            end
            TMR_RUN: begin
                if (!run_q) begin
                    state_d = TMR_IDLE;
                end else if (cnt_q == '0) begin
                    tick  = 1'b1;
                    cnt_d = period_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = TMR_IDLE;
            end
        endcase
    end

    assign buf_mode = buf_mode_q;
    assign period   = period_q;

endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
    import dma_req_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_BITS-1:0]  cfg_wdata,
    input  logic                 src_req,
    input  logic                 dst_req,
    input  logic [EXT_LINES-1:0] ext_sync,
    input  logic                 tick,
    input  logic                 buf_mode,
    input  logic                 xfer_ack,
    input  logic                 buf_done,
    output logic                 req_vld,
    output logic                 req_whole_buf,
    output ch_cfg_t              cfg_o,
    output logic                 pend_o
);

    ch_cfg_t     cfg_q;
    pend_state_t state_q, state_d;
    logic        periph_ok;
    logic        ext_ok;
    logic        tmr_ok;
    logic        consume;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= ch_cfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PEND_EMPTY;
        end else begin
            state_d_apply: state_q <= state_d;
        end
    end

    assign consume = buf_mode ? buf_done : xfer_ack;

    // release FSM transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_EMPTY: begin
                if (cfg_q.tmr_en && tick) begin
                    state_d = PEND_HELD;
                end
            end
            PEND_HELD: begin
                if (!cfg_q.tmr_en) begin
                    state_d = PEND_EMPTY;
                end else if (consume && !tick) begin
                    state_d = PEND_EMPTY;
                end
            end
            default: begin
                state_d = PEND_EMPTY;
            end
        endcase
    end

    // qualified request outputs
    always_comb begin
        if (cfg_q.src_io) begin
            periph_ok = src_req;
        end else if (cfg_q.dst_io) begin
            periph_ok = dst_req;
        end else begin
            periph_ok = 1'b1;
        end
        ext_ok        = !cfg_q.ext_en || ext_sync[cfg_q.ext_sel];
        tmr_ok        = !cfg_q.tmr_en || (state_q == PEND_HELD);
        req_vld       = periph_ok && ext_ok && tmr_ok;
        req_whole_buf = cfg_q.tmr_en && buf_mode;
    end

    assign cfg_o  = cfg_q;
    assign pend_o = (state_q == PEND_HELD);

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
    import dma_req_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(N_CH + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [TMR_W-1:0]     cfg_wdata,
    input  logic [EXT_LINES-1:0] ext_req_in,
    input  logic [N_CH-1:0]      periph_src_req,
    input  logic [N_CH-1:0]      periph_dst_req,
    input  logic [N_CH-1:0]      xfer_ack,
    input  logic [N_CH-1:0]      buf_done,
    output logic [N_CH-1:0]      req_vld,
    output logic [N_CH-1:0]      req_whole_buf
);

    localparam logic [AW-1:0] ADDR_PERIOD = AW'(N_CH);
    localparam logic [AW-1:0] ADDR_CTL    = AW'(N_CH + 1);

    logic [EXT_LINES-1:0] ext_sync;
    logic                 tick;
    logic                 buf_mode;
    logic [TMR_W-1:0]     period;
    logic [N_CH-1:0]      cfg_src_io;
    logic [N_CH-1:0]      cfg_dst_io;
    logic [N_CH-1:0]      cfg_ext_en;
    logic [N_CH-1:0]      cfg_ext_sel;
    logic [N_CH-1:0]      cfg_tmr_en;
    logic [N_CH-1:0]      pend;

    dma_req_sync #(
        .WIDTH (EXT_LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ext_req_in),
        .q    (ext_sync)
    );

    dma_req_timer #(
        .CNT_W(TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_we(cfg_we && (cfg_addr == ADDR_PERIOD)),
        .ctl_we   (cfg_we && (cfg_addr == ADDR_CTL)),
        .wdata    (cfg_wdata),
        .tick     (tick),
        .buf_mode (buf_mode),
        .period   (period)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        ch_cfg_t ch_cfg;

        dma_req_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_we       (cfg_we && (cfg_addr == AW'(g))),
            .cfg_wdata    (cfg_wdata[CFG_BITS-1:0]),
            .src_req      (periph_src_req[g]),
            .dst_req      (periph_dst_req[g]),
            .ext_sync     (ext_sync),
            .tick         (tick),
            .buf_mode     (buf_mode),
            .xfer_ack     (xfer_ack[g]),
            .buf_done     (buf_done[g]),
            .req_vld      (req_vld[g]),
            .req_whole_buf(req_whole_buf[g]),
            .cfg_o        (ch_cfg),
            .pend_o       (pend[g])
        );

        assign cfg_src_io[g]  = ch_cfg.src_io;
        assign cfg_dst_io[g]  = ch_cfg.dst_io;
        assign cfg_ext_en[g]  = ch_cfg.ext_en;
        assign cfg_ext_sel[g] = ch_cfg.ext_sel;
        assign cfg_tmr_en[g]  = ch_cfg.tmr_en;
    end

endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
    parameter int N_CH  = 8,
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CH-1:0]  req_vld,
    input logic [N_CH-1:0]  req_whole_buf,
    input logic [N_CH-1:0]  periph_src_req,
    input logic [N_CH-1:0]  periph_dst_req,
    input logic [N_CH-1:0]  xfer_ack,
    input logic [N_CH-1:0]  buf_done,
    input logic [N_CH-1:0]  cfg_src_io,
    input logic [N_CH-1:0]  cfg_dst_io,
    input logic [N_CH-1:0]  cfg_ext_en,
    input logic [N_CH-1:0]  cfg_ext_sel,
    input logic [N_CH-1:0]  cfg_tmr_en,
    input logic [N_CH-1:0]  pend,
    input logic [1:0]       ext_sync,
    input logic             tick,
    input logic             buf_mode,
    input logic [TMR_W-1:0] period
);

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (period != '0) |=> !tick);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        assert_mem_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_src_io[g] && !cfg_dst_io[g] && !cfg_ext_en[g] && !cfg_tmr_en[g]
            |-> req_vld[g]);

        assert_src_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_src_io[g] && !periph_src_req[g] |-> !req_vld[g]);

        assert_dst_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_src_io[g] && cfg_dst_io[g] && !periph_dst_req[g] |-> !req_vld[g]);

        assert_ext_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_ext_en[g] && !ext_sync[cfg_ext_sel[g]] |-> !req_vld[g]);

        assert_tmr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_tmr_en[g] && !pend[g] |-> !req_vld[g]);

        assert_tick_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tick && cfg_tmr_en[g] |=> pend[g]);

        assert_byte_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && cfg_tmr_en[g] && !buf_mode && xfer_ack[g] && !tick |=> !pend[g]);

        assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && cfg_tmr_en[g] && buf_mode && !buf_done[g] |=> pend[g]);

        assert_whole_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
            req_whole_buf[g] |-> cfg_tmr_en[g] && buf_mode);
    end

endmodule

bind dma_req_gate dma_req_gate_chk #(
    .N_CH (N_CH),
    .TMR_W(TMR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vld       (req_vld),
    .req_whole_buf (req_whole_buf),
    .periph_src_req(periph_src_req),
    .periph_dst_req(periph_dst_req),
    .xfer_ack      (xfer_ack),
    .buf_done      (buf_done),
    .cfg_src_io    (cfg_src_io),
    .cfg_dst_io    (cfg_dst_io),
    .cfg_ext_en    (cfg_ext_en),
    .cfg_ext_sel   (cfg_ext_sel),
    .cfg_tmr_en    (cfg_tmr_en),
    .pend          (pend),
    .ext_sync      (ext_sync),
    .tick          (tick),
    .buf_mode      (buf_mode),
    .period        (period)
);

// File: tb/dma_req_gate_bench.sv
module dma_req_gate_bench;

    localparam int N_CH  = 4;
    localparam int TMR_W = 16;
    localparam int AW    = $clog2(N_CH + 2);
    localparam int PER   = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [TMR_W-1:0] cfg_wdata = '0;
    logic [1:0]       ext_req_in = '0;
    logic [N_CH-1:0]  periph_src_req = '0;
    logic [N_CH-1:0]  periph_dst_req = '0;
    logic [N_CH-1:0]  xfer_ack = '0;
    logic [N_CH-1:0]  buf_done = '0;
    logic [N_CH-1:0]  req_vld;
    logic [N_CH-1:0]  req_whole_buf;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dma_req_gate #(.N_CH(N_CH), .TMR_W(TMR_W)) u_dma_req_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .ext_req_in    (ext_req_in),
        .periph_src_req(periph_src_req),
        .periph_dst_req(periph_dst_req),
        .xfer_ack      (xfer_ack),
        .buf_done      (buf_done),
        .req_vld       (req_vld),
        .req_whole_buf (req_whole_buf)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(addr);
        cfg_wdata = TMR_W'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(input int ch, input int lim, output int cyc);
        cyc = 0;
        while (!req_vld[ch] && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // model for channels without the timer: bits src_io, dst_io, ext_en, ext_sel
    function automatic logic exp_req(logic [4:0] c, logic s, logic d, logic [1:0] e);
        logic r;
        r = c[0] ? s : (c[1] ? d : 1'b1);
        if (c[2]) r = r & e[c[3]];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [4:0] cf [N_CH];
        int c;
        int t0;
        int t1;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        check(req_vld == 4'hF, "R10 req after reset", 32'(req_vld), 32'hF);
        check(req_whole_buf == 4'h0, "R10 whole_buf after reset", 32'(req_whole_buf), 0);

        // R1 R2 R3 random combinations without timer
        for (int it = 0; it < 150; it++) begin
            logic [N_CH-1:0] e;
            for (int ch = 0; ch < N_CH; ch++) begin
                cf[ch] = 5'($urandom() & 32'hF);
                wr(ch, int'(cf[ch]));
            end
            periph_src_req = N_CH'($urandom());
            periph_dst_req = N_CH'($urandom());
            ext_req_in     = 2'($urandom());
            step(3);
            for (int ch = 0; ch < N_CH; ch++) e[ch] = exp_req(cf[ch], periph_src_req[ch],
                                                            periph_dst_req[ch], ext_req_in);
            check(req_vld == e, "R1 R2 R3 random AND", 32'(req_vld), 32'(e));
        end

        // R2 both source and destination are I/O: source governs
        wr(0, 5'b00011);
        periph_src_req[0] = 1'b0; periph_dst_req[0] = 1'b1;
        step(1);
        check(req_vld[0] == 1'b0, "R2 src low dst high", 32'(req_vld[0]), 0);
        periph_src_req[0] = 1'b1; periph_dst_req[0] = 1'b0;
        step(1);
        check(req_vld[0] == 1'b1, "R2 src high dst low", 32'(req_vld[0]), 1);

        // R3 synchronizer latency on pin 1
        wr(0, 5'b01100);
        ext_req_in = 2'b00;
        step(3);
        check(req_vld[0] == 1'b0, "R3 pin low", 32'(req_vld[0]), 0);
        ext_req_in = 2'b10;
        step(1);
        check(req_vld[0] == 1'b0, "R3 after one edge", 32'(req_vld[0]), 0);
        step(1);
        check(req_vld[0] == 1'b1, "R3 after two edges", 32'(req_vld[0]), 1);

        // timer on channel 1 only, byte mode
        for (int ch = 0; ch < N_CH; ch++) wr(ch, 0);
        wr(1, 5'b10000);
        check(req_vld[1] == 1'b0, "R5 no release yet", 32'(req_vld[1]), 0);
        wr(N_CH, PER);
        wr(N_CH + 1, 1);
        wait_rise(1, 200, c);
        check(req_vld[1] == 1'b1, "R5 tick releases", 32'(req_vld[1]), 1);
        check(req_whole_buf[1] == 1'b0, "R9 byte mode", 32'(req_whole_buf[1]), 0);
        check(req_vld[0] == 1'b1, "R1 untimed channel unaffected", 32'(req_vld[0]), 1);
        // R4 spacing with immediate acknowledge
        t0 = 0;
        for (int k = 0; k < 3; k++) begin
            xfer_ack[1] = 1'b1;
            step(1);
            xfer_ack[1] = 1'b0;
            check(req_vld[1] == 1'b0, "R6 ack clears", 32'(req_vld[1]), 0);
            wait_rise(1, 200, c);
            check(c + 1 == PER + 1, "R4 tick spacing", 32'(c + 1), PER + 1);
        end
        // R6 buf_done ignored in byte mode
        buf_done[1] = 1'b1;
        step(1);
        buf_done[1] = 1'b0;
        step(1);
        check(req_vld[1] == 1'b1, "R6 buf_done ignored", 32'(req_vld[1]), 1);
        // R8 two more ticks while pending, one ack empties it
        t1 = 2;
        step(88);
        xfer_ack[1] = 1'b1;
        step(1);
        xfer_ack[1] = 1'b0;
        check(req_vld[1] == 1'b0, "R8 single consume", 32'(req_vld[1]), 0);
        for (int k = 0; k < 25; k++) begin
            step(1);
            if (req_vld[1]) t1 = 1;
        end
        check(t1 == 2, "R8 no extra release", 32'(t1), 2);

        // R7 whole-buffer mode
        wr(N_CH + 1, 3);
        wait_rise(1, 200, c);
        check(req_whole_buf[1] == 1'b1, "R9 buffer mode", 32'(req_whole_buf[1]), 1);
        xfer_ack[1] = 1'b1;
        step(1);
        xfer_ack[1] = 1'b0;
        step(1);
        check(req_vld[1] == 1'b1, "R7 ack ignored", 32'(req_vld[1]), 1);
        buf_done[1] = 1'b1;
        step(1);
        buf_done[1] = 1'b0;
        check(req_vld[1] == 1'b0, "R7 buf_done clears", 32'(req_vld[1]), 0);

        // R11 stop keeps pending release
        wait_rise(1, 200, c);
        wr(N_CH + 1, 2);
        step(100);
        check(req_vld[1] == 1'b1, "R11 pending kept", 32'(req_vld[1]), 1);
        // R5 unassigning the timer drops the pending release
        wr(1, 0);
        wr(1, 5'b10000);
        check(req_vld[1] == 1'b0, "R5 unassign clears", 32'(req_vld[1]), 0);
        step(100);
        check(req_vld[1] == 1'b0, "R11 no ticks when stopped", 32'(req_vld[1]), 0);

        // R4 period zero with R8 tick and ack together; R1 timer AND pin 0
        wr(2, 5'b10100);
        ext_req_in = 2'b00;
        wr(N_CH, 0);
        wr(N_CH + 1, 1);
        step(4);
        xfer_ack[1] = 1'b1;
        t1 = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (!req_vld[1]) t1++;
        end
        xfer_ack[1] = 1'b0;
        check(t1 == 0, "R4 R8 period zero", 32'(t1), 0);
        check(req_vld[2] == 1'b0, "R1 timer and pin low", 32'(req_vld[2]), 0);
        ext_req_in = 2'b01;
        step(3);
        check(req_vld[2] == 1'b1, "R1 timer and pin high", 32'(req_vld[2]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule